// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status FIFO

This block turns an asynchronous serial input into bytes. A separate baud generator supplies a one-cycle oversampling tick, `OS` ticks per bit. The receiver finds a start edge and confirms it half a bit later. It then samples each data bit, the optional parity bit and one or two stop bits at the centre of the bit. Characters may carry 5 to 8 data bits. Each finished character goes into a small FIFO together with its own framing, parity and break flags. The error flags therefore travel with the data they describe.

Software reads the FIFO through a register-style port. The data and the flags on the port always describe the oldest entry. A single read strobe pops that entry, after which the port shows the next one. An overrun flag is kept outside the FIFO because it describes a lost character and not a stored one.

Three level interrupt requests are produced, each gated by its own enable input: FIFO fill at or above a trigger level, a receive error, and an idle timeout. The timeout is counted in character times. A clear strobe empties the FIFO, and a receiver enable input starts or aborts reception.

Top module: `serial_rx_fifo`

## Requirements
- R1: `cfg_wsize` selects the number of data bits. The values 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data is received LSB first and presented right-aligned on `rd_data`, with the unused upper bits at zero.
- R2: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 selects even parity and 0 selects odd parity. A mismatch sets `st_par` for that entry. With `cfg_par_en`=0 no parity bit is expected and `st_par` stays 0.
- R3: `cfg_two_stop`=0 expects one stop bit and 1 expects two. A stop bit sampled low sets `st_frm` for that entry.
- R4: A line held low for a whole frame, stop bits included, produces exactly one entry with data 0, `st_brk`=1, `st_frm`=0 and `st_par`=0. No further entry is produced until the line has returned high.
- R5: The FIFO holds `DEPTH` entries. `st_avail` is 1 whenever `fifo_count`>=1. `rd_data` and the flags show the oldest entry, and a `rd_strobe` pulse pops it so that the next entry appears. Flags read as 0 while the FIFO is empty.
- R6: If a character completes while the FIFO is full, the character is dropped, `fifo_count` stays at `DEPTH` and `st_ovr` is set. `st_ovr` stays set until `rd_strobe` or `fifo_clr`.
- R7: A `fifo_clr` pulse empties the FIFO and clears `st_ovr`.
- R8: While `rx_en`=0 nothing is received, and a character in progress is abandoned.
- R9: `irq_thr` = `irq_en_thr` AND (`fifo_count` >= `trig_level`).
- R10: `irq_err` = `irq_en_err` AND (`st_ovr` OR the head entry carries a framing, parity or break flag).
- R11: `irq_to` rises when `irq_en_to`=1, the FIFO is not empty, and no push, pop or clear has occurred for 4 character times. One character time is (1 + data bits + parity bit + stop bits) × `OS` ticks. Any FIFO activity drops `irq_to`.
- R12: A low pulse on the line shorter than half a bit is not taken as a start bit and produces no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OS per bit |
| rx_en | input | 1 | Receiver enable |
| rx_line | input | 1 | Serial input, idle high |
| cfg_wsize | input | 2 | Data bits: 0..3 gives 5..8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even, 0 odd parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| fifo_clr | input | 1 | Clear strobe for the FIFO and overrun |
| rd_strobe | input | 1 | Pops the head entry |
| trig_level | input | CW | Threshold for irq_thr |
| irq_en_thr | input | 1 | Threshold interrupt enable |
| irq_en_err | input | 1 | Error interrupt enable |
| irq_en_to | input | 1 | Timeout interrupt enable |
| rd_data | output | 8 | Head entry data |
| st_avail | output | 1 | FIFO not empty |
| st_ovr | output | 1 | Sticky overrun |
| st_frm | output | 1 | Head framing error |
| st_par | output | 1 | Head parity error |
| st_brk | output | 1 | Head break |
| fifo_count | output | CW | Number of entries |
| irq_thr | output | 1 | Threshold request |
| irq_err | output | 1 | Error request |
| irq_to | output | 1 | Idle timeout request |

## Verification
The bench checks that flags stay attached to their own entry. After a bad-parity character is popped, a good character behind it must read clean; a design that kept the errors in one shared status word would leak the flag onto it. It fills the FIFO and sends one more character. A design that overwrote the oldest entry, or let the count wrap, would show the wrong head data or count instead of a sticky overrun. It also sends a break, a runt start pulse and a character while the receiver is disabled; a weak start check or a missing enable gate would make entries appear. The idle timeout is checked just before and just after four character times, so a timeout counted in bits or in clocks fires at the wrong time.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef struct packed {
      logic       brk;
      logic       par;
      logic       frm;
      logic [7:0] data;
   } srx_entry_t;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT_HIGH
   } srx_state_t;

   // Bits in one character: start + data + parity + stop(s)
   function automatic logic [3:0] srx_char_bits(input logic [1:0] ws,
                                                 input logic pe,
                                                 input logic ts);
      return 4'd7 + {2'b00, ws} + {3'b000, pe} + {3'b000, ts};
   endfunction

endpackage

// File: rtl/srx_deframer.sv
module srx_deframer
   import srx_pkg::*;
#(
   parameter int OS          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       line,
   input  logic [1:0] wsize,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       two_stop,
   output logic       push,
   output srx_entry_t entry
);
   localparam int CNTW = $clog2(OS);
   localparam logic [CNTW-1:0] LAST_TICK = CNTW'(OS - 1);
   localparam logic [CNTW-1:0] MID_TICK  = CNTW'(OS / 2 - 1);

   if (OS < 4 || (OS % 2) != 0) begin : g_bad_os
      $error("OS must be even and at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic ln;
   if (SYNC_STAGES == 1) begin : g_sync1
      logic sq;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sq <= 1'b1;
         else        sq <= line;
      assign ln = sq;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sq <= '1;
         else        sq <= {sq[SYNC_STAGES-2:0], line};
      assign ln = sq[SYNC_STAGES-1];
   end

   srx_state_t      state;
   logic [CNTW-1:0] cnt;
   logic [2:0]      bitn;
   logic [7:0]      sh;
   logic            all_low, parbit, stop2, stop_bad;

   logic [2:0] last_bit;
   logic [7:0] data_al;
   logic       stop_bad_n, all_low_n, perr, at_end;

   always_comb begin
      last_bit = {1'b0, wsize} + 3'd4;
      case (wsize)
         2'd0:    data_al = {3'b000, sh[7:3]};
         2'd1:    data_al = {2'b00,  sh[7:2]};
         2'd2:    data_al = {1'b0,   sh[7:1]};
         default: data_al = sh;
      endcase
      stop_bad_n = stop_bad | ~ln;
      all_low_n  = all_low & ~ln;
      perr       = (^data_al) ^ parbit ^ ~par_even;
      at_end     = tick && (cnt == LAST_TICK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         sh       <= '0;
         all_low  <= 1'b0;
         parbit   <= 1'b0;
         stop2    <= 1'b0;
         stop_bad <= 1'b0;
         push     <= 1'b0;
         entry    <= '0;
      end else begin
         push <= 1'b0;
         if (!en) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE:
                  if (tick && !ln) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               RX_START:
                  if (tick) begin
                     if (cnt == MID_TICK) begin
                        if (ln) begin
                           state <= RX_IDLE;
                        end else begin
                           state   <= RX_DATA;
                           cnt     <= '0;
                           bitn    <= '0;
                           sh      <= '0;
                           all_low <= 1'b1;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               RX_DATA:
                  if (at_end) begin
                     cnt     <= '0;
                     sh      <= {ln, sh[7:1]};
                     all_low <= all_low_n;
                     if (bitn == last_bit) begin
                        state    <= par_en ? RX_PAR : RX_STOP;
                        stop2    <= 1'b0;
                        stop_bad <= 1'b0;
                     end else begin
                        bitn <= bitn + 1'b1;
                     end
                  end else if (tick) begin
                     cnt <= cnt + 1'b1;
                  end
               RX_PAR:
                  if (at_end) begin
                     cnt     <= '0;
                     parbit  <= ln;
                     all_low <= all_low_n;
                     state   <= RX_STOP;
                  end else if (tick) begin
                     cnt <= cnt + 1'b1;
                  end
               RX_STOP:
                  if (at_end) begin
                     cnt <= '0;
                     if (two_stop && !stop2) begin
                        stop2    <= 1'b1;
                        stop_bad <= stop_bad_n;
                        all_low  <= all_low_n;
                     end else begin
                        push <= 1'b1;
                        if (all_low_n) begin
                           entry <= '{brk: 1'b1, par: 1'b0, frm: 1'b0, data: 8'h00};
                           state <= RX_WAIT_HIGH;
                        end else begin
                           entry <= '{brk: 1'b0, par: par_en & perr,
                                      frm: stop_bad_n, data: data_al};
                           state <= stop_bad_n ? RX_WAIT_HIGH : RX_IDLE;
                        end
                     end
                  end else if (tick) begin
                     cnt <= cnt + 1'b1;
                  end
               default:
                  if (tick && ln) state <= RX_IDLE;
            endcase
         end
      end
   end

   assert_dis_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !push);
   assert_break_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && entry.brk) |-> (entry.data == 8'h00 && !entry.frm && !entry.par));
   assert_push_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          rd,
   input  logic          clr,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          ovr,
   output logic          pop_ok
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   logic [AW-1:0] wp, rp;
   logic [W-1:0]  mem [DEPTH];
   logic          push_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign pop_ok  = rd && !empty && !clr;
   assign push_ok = push && !clr && (!full || pop_ok);
   assign dout    = mem[rp];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk)
         if (push_ok && wp == AW'(i)) mem[i] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         ovr   <= 1'b0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         ovr   <= 1'b0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         count <= count + CW'(push_ok) - CW'(pop_ok);
         if (rd)                ovr <= 1'b0;
         else if (push && full) ovr <= 1'b1;
      end
   end

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_drop_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !rd && !clr) |=> (count == $past(count)));
   assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !rd && !clr) |=> ovr);
   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (empty && !ovr));

endmodule

// File: rtl/srx_irq.sv
module srx_irq
   import srx_pkg::*;
#(
   parameter int OS         = 16,
   parameter int CW         = 4,
   parameter int IDLE_CHARS = 4,
   localparam int TOW       = $clog2(12 * OS * IDLE_CHARS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] trig,
   input  logic          empty,
   input  logic          head_err,
   input  logic          ovr,
   input  logic          activity,
   input  logic [1:0]    wsize,
   input  logic          par_en,
   input  logic          two_stop,
   input  logic          en_thr,
   input  logic          en_err,
   input  logic          en_to,
   output logic          irq_thr,
   output logic          irq_err,
   output logic          irq_to
);
   if (IDLE_CHARS < 1) begin : g_bad_idle
      $error("IDLE_CHARS must be at least 1");
   end

   logic [TOW-1:0] idle_cnt, limit;

   assign limit = TOW'(srx_char_bits(wsize, par_en, two_stop)) * TOW'(OS * IDLE_CHARS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   idle_cnt <= '0;
      else if (activity || empty)   idle_cnt <= '0;
      else if (tick && idle_cnt < limit) idle_cnt <= idle_cnt + 1'b1;
   end

   assign irq_thr = en_thr && (count >= trig);
   assign irq_err = en_err && (ovr || (!empty && head_err));
   assign irq_to  = en_to && !empty && (idle_cnt >= limit);

   assert_to_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
      activity |=> !irq_to);
   assert_to_needs_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_to) |-> ($past(!activity) && $past(!empty)));

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
   import srx_pkg::*;
#(
   parameter int OS          = 16,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_CHARS  = 4,
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          os_tick,
   input  logic          rx_en,
   input  logic          rx_line,
   input  logic [1:0]    cfg_wsize,
   input  logic          cfg_par_en,
   input  logic          cfg_par_even,
   input  logic          cfg_two_stop,
   input  logic          fifo_clr,
   input  logic          rd_strobe,
   input  logic [CW-1:0] trig_level,
   input  logic          irq_en_thr,
   input  logic          irq_en_err,
   input  logic          irq_en_to,
   output logic [7:0]    rd_data,
   output logic          st_avail,
   output logic          st_ovr,
   output logic          st_frm,
   output logic          st_par,
   output logic          st_brk,
   output logic [CW-1:0] fifo_count,
   output logic          irq_thr,
   output logic          irq_err,
   output logic          irq_to
);
   localparam int EW = $bits(srx_entry_t);

   logic       push, empty, full, pop_ok;
   srx_entry_t new_e, head;
   logic [EW-1:0] head_raw;

   srx_deframer #(.OS(OS), .SYNC_STAGES(SYNC_STAGES)) u_deframe (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(rx_en), .line(rx_line),
      .wsize(cfg_wsize), .par_en(cfg_par_en), .par_even(cfg_par_even),
      .two_stop(cfg_two_stop), .push(push), .entry(new_e)
   );

   srx_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(new_e), .rd(rd_strobe),
      .clr(fifo_clr), .dout(head_raw), .count(fifo_count), .empty(empty),
      .full(full), .ovr(st_ovr), .pop_ok(pop_ok)
   );

   assign head     = empty ? '0 : srx_entry_t'(head_raw);
   assign rd_data  = head.data;
   assign st_frm   = head.frm;
   assign st_par   = head.par;
   assign st_brk   = head.brk;
   assign st_avail = !empty;

   srx_irq #(.OS(OS), .CW(CW), .IDLE_CHARS(IDLE_CHARS)) u_irq (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .count(fifo_count),
      .trig(trig_level), .empty(empty),
      .head_err(head.frm | head.par | head.brk), .ovr(st_ovr),
      .activity(push | pop_ok | fifo_clr), .wsize(cfg_wsize),
      .par_en(cfg_par_en), .two_stop(cfg_two_stop), .en_thr(irq_en_thr),
      .en_err(irq_en_err), .en_to(irq_en_to), .irq_thr(irq_thr),
      .irq_err(irq_err), .irq_to(irq_to)
   );

endmodule

// File: tb/serial_rx_fifo_tb_top.sv
module serial_rx_fifo_tb_top;
   localparam int OS    = 16;
   localparam int DEPTH = 8;
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int TDIV  = 4;
   localparam int BITCLK = OS * TDIV;

   logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
   logic rx_en = 1'b1, rx_line = 1'b1;
   logic [1:0] cfg_wsize = 2'd3;
   logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
   logic fifo_clr = 1'b0, rd_strobe = 1'b0;
   logic [CW-1:0] trig_level = CW'(4);
   logic irq_en_thr = 1'b1, irq_en_err = 1'b1, irq_en_to = 1'b0;
   logic [7:0] rd_data;
   logic st_avail, st_ovr, st_frm, st_par, st_brk, irq_thr, irq_err, irq_to;
   logic [CW-1:0] fifo_count;

   int checks = 0, errors = 0;
   bit cmp_on = 1'b0;
   logic [10:0] exp_q[$];   // {brk, par, frm, data}
   bit model_ovr = 1'b0;
   int tdiv = 0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      tdiv = (tdiv + 1) % TDIV;
      os_tick = (tdiv == 0);
   end

   serial_rx_fifo #(.OS(OS), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
      .rx_line(rx_line), .cfg_wsize(cfg_wsize), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
      .fifo_clr(fifo_clr), .rd_strobe(rd_strobe), .trig_level(trig_level),
      .irq_en_thr(irq_en_thr), .irq_en_err(irq_en_err), .irq_en_to(irq_en_to),
      .rd_data(rd_data), .st_avail(st_avail), .st_ovr(st_ovr), .st_frm(st_frm),
      .st_par(st_par), .st_brk(st_brk), .fifo_count(fifo_count),
      .irq_thr(irq_thr), .irq_err(irq_err), .irq_to(irq_to)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Reference model compared on every clock while no frame is in flight
   always @(posedge clk) begin
      #2;
      if (rst_n && cmp_on) begin
         chk("R5", "count", 32'(fifo_count), 32'(exp_q.size()));
         chk("R5", "avail", 32'(st_avail), 32'(exp_q.size() > 0));
         chk("R6", "ovr", 32'(st_ovr), 32'(model_ovr));
         chk("R9", "irq_thr", 32'(irq_thr),
             32'(irq_en_thr && (exp_q.size() >= int'(trig_level))));
         chk("R10", "irq_err", 32'(irq_err), 32'(irq_en_err && (model_ovr ||
             (exp_q.size() > 0 && (|exp_q[0][10:8])))));
      end
   end

   task automatic wait_bits(input int n);
      repeat (n * BITCLK) @(negedge clk);
   endtask

   task automatic drive_frame(input logic [7:0] d, input bit badpar, input bit badstop);
      int nb;
      logic [7:0] dd;
      nb = 5 + int'(cfg_wsize);
      dd = d & 8'((1 << nb) - 1);
      rx_line = 1'b0;
      wait_bits(1);
      for (int i = 0; i < nb; i++) begin
         rx_line = dd[i];
         wait_bits(1);
      end
      if (cfg_par_en) begin
         rx_line = (cfg_par_even ? ^dd : ~^dd) ^ badpar;
         wait_bits(1);
      end
      rx_line = ~badstop;
      wait_bits(1);
      rx_line = 1'b1;
      if (cfg_two_stop) wait_bits(1);
      wait_bits(1);
   endtask

   task automatic model_push(input logic [10:0] e);
      if (exp_q.size() < DEPTH) exp_q.push_back(e);
      else model_ovr = 1'b1;
   endtask

   task automatic send_frame(input logic [7:0] d, input bit badpar, input bit badstop);
      logic [7:0] dd;
      cmp_on = 1'b0;
      drive_frame(d, badpar, badstop);
      dd = d & 8'((1 << (5 + int'(cfg_wsize))) - 1);
      model_push({1'b0, cfg_par_en & badpar, badstop, dd});
      cmp_on = 1'b1;
   endtask

   task automatic read_check(input string req);
      logic [10:0] e;
      if (exp_q.size() > 0) begin
         e = exp_q[0];
         chk(req, "rd_data", 32'(rd_data), 32'(e[7:0]));
         chk(req, "flags brk/par/frm", 32'({st_brk, st_par, st_frm}), 32'(e[10:8]));
      end else begin
         chk(req, "empty avail", 32'(st_avail), 32'd0);
      end
      cmp_on = 1'b0;
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      model_ovr = 1'b0;
      cmp_on = 1'b1;
   endtask

   task automatic clear_fifo();
      cmp_on = 1'b0;
      fifo_clr = 1'b1;
      @(negedge clk);
      fifo_clr = 1'b0;
      exp_q.delete();
      model_ovr = 1'b0;
      cmp_on = 1'b1;
   endtask

   task automatic set_cfg(input logic [1:0] ws, input bit pe, input bit pev, input bit ts);
      cfg_wsize = ws; cfg_par_en = pe; cfg_par_even = pev; cfg_two_stop = ts;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk("R5", "reset count", 32'(fifo_count), 32'd0);
      chk("R6", "reset ovr", 32'(st_ovr), 32'd0);
      chk("R11", "reset irq_to", 32'(irq_to), 32'd0);
      cmp_on = 1'b1;
      wait_bits(2);

      // R1: 8 data bits, no parity, one stop
      set_cfg(2'd3, 0, 0, 0);
      send_frame(8'hA5, 0, 0);
      send_frame(8'h3C, 0, 0);
      read_check("R1");
      read_check("R5");
      read_check("R5");   // empty read

      // R1: smaller word sizes, upper bits zero; R3 two stop bits
      set_cfg(2'd0, 0, 0, 0);
      send_frame(8'hF5, 0, 0);
      set_cfg(2'd1, 0, 0, 1);
      send_frame(8'hEA, 0, 0);
      set_cfg(2'd2, 0, 0, 1);
      send_frame(8'hD5, 0, 0);
      read_check("R1");
      read_check("R1");
      read_check("R3");

      // R2: parity even good, odd good, even bad; R10 error irq
      set_cfg(2'd3, 1, 1, 0);
      send_frame(8'h37, 0, 0);
      send_frame(8'h37, 1, 0);
      set_cfg(2'd3, 1, 0, 0);
      send_frame(8'h81, 0, 0);
      read_check("R2");
      chk("R10", "irq_err on bad parity head", 32'(irq_err), 32'd1);
      read_check("R2");
      chk("R10", "irq_err on clean head", 32'(irq_err), 32'd0);
      read_check("R2");

      // R3: framing error on a bad stop bit
      set_cfg(2'd3, 0, 0, 0);
      send_frame(8'h5A, 0, 1);
      chk("R3", "st_frm", 32'(st_frm), 32'd1);
      read_check("R3");

      // R4: break
      cmp_on = 1'b0;
      rx_line = 1'b0;
      wait_bits(14);
      rx_line = 1'b1;
      wait_bits(2);
      model_push(11'h400);
      cmp_on = 1'b1;
      chk("R4", "single break entry", 32'(fifo_count), 32'd1);
      read_check("R4");

      // R12: runt start pulse
      rx_line = 1'b0;
      repeat (3 * TDIV) @(negedge clk);
      rx_line = 1'b1;
      wait_bits(12);
      chk("R12", "runt start ignored", 32'(fifo_count), 32'd0);

      // R8: receiver disabled
      rx_en = 1'b0;
      cmp_on = 1'b0;
      drive_frame(8'h66, 0, 0);
      cmp_on = 1'b1;
      rx_en = 1'b1;
      wait_bits(1);
      chk("R8", "disabled no entry", 32'(fifo_count), 32'd0);

      // R9: threshold
      trig_level = CW'(3);
      send_frame(8'h01, 0, 0);
      send_frame(8'h02, 0, 0);
      chk("R9", "below trigger", 32'(irq_thr), 32'd0);
      send_frame(8'h03, 0, 0);
      chk("R9", "at trigger", 32'(irq_thr), 32'd1);
      clear_fifo();
      chk("R7", "clear empties", 32'(fifo_count), 32'd0);

      // R6: overrun
      for (int i = 0; i < DEPTH; i++) send_frame(8'(8'h10 + i), 0, 0);
      send_frame(8'hEE, 0, 0);
      chk("R6", "overrun count", 32'(fifo_count), 32'(DEPTH));
      chk("R6", "overrun flag", 32'(st_ovr), 32'd1);
      read_check("R6");
      chk("R6", "ovr cleared by read", 32'(st_ovr), 32'd0);
      send_frame(8'hEF, 0, 0);
      send_frame(8'hF0, 0, 0);
      chk("R6", "ovr again", 32'(st_ovr), 32'd1);
      clear_fifo();
      chk("R7", "clear drops ovr", 32'(st_ovr), 32'd0);

      // R11: idle timeout, 8N1 -> 4 x 10 x 16 ticks = 2560 clocks
      irq_en_to = 1'b1;
      send_frame(8'h42, 0, 0);
      repeat (2300) @(negedge clk);
      chk("R11", "no timeout early", 32'(irq_to), 32'd0);
      repeat (400) @(negedge clk);
      chk("R11", "timeout fired", 32'(irq_to), 32'd1);
      read_check("R11");
      chk("R11", "timeout cleared", 32'(irq_to), 32'd0);

      wait_bits(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule